// File: doc/BRIEF.md
# Nine-Bit Serial Frame Transmitter

This block turns one host write into an eleven-bit asynchronous serial frame on a single line. The frame is a low start bit, eight payload bits sent least significant first, a ninth bit chosen by the host, and a high stop bit. The ninth bit is commonly used as an address/data marker on multi-drop links or as a parity bit computed by software. When the ninth bit has been sent, the block raises a sticky completion flag that stays set until software clears it.

Bit timing comes from a 16x oversampling counter. That counter advances on a sample tick, which is either the system clock divided by a fast or slow ratio or a pulse from an external timer overflow. A frame never starts on the write itself. It waits for the next wrap of the oversampling counter, so every bit edge on the line lines up with that counter. The block does not count bits. The shift register marks itself: the first shift feeds in a single 1, every later shift feeds in zeros, and the block knows the frame is ending when that 1 sits just behind the ninth bit and nothing but zeros lies beyond it.

The write side is a valid/ready handshake. `wr_ready` is high only while the block is idle, meaning no frame is pending and none is on the line. A beat is taken on a clock edge where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low, the host must hold its beat or drop it, and `wr_valid` has no effect. `wr_ready` does not depend on `wr_valid`.

Top module: `uart9_tx`

## Requirements
- R1: After reset, `txd` is 1, `done` is 0 and `wr_ready` is 1.
- R2: A write is taken on an edge where `wr_valid` and `wr_ready` are both 1. It captures `wr_data` and `wr_bit9`, and `wr_ready` is 0 from the next cycle until the frame ends.
- R3: After a write is taken, `txd` stays 1 until the first wrap of the oversampling counter that comes strictly after the accepting edge. A wrap in the same cycle as the accepting edge does not start the frame. With a sample tick every clock, the line therefore falls exactly 16 clocks after the accepting edge when the write coincides with a wrap.
- R4: The frame on `txd` is: 0 for one bit time, then `wr_data[0]` through `wr_data[7]`, then `wr_bit9`, each held for one bit time (16 sample ticks), and then 1.
- R5: At the wrap that ends the ninth bit, all of the following happen in the same cycle: `txd` returns to 1, `done` rises, and `wr_ready` returns to 1. This is 10 bit times after the start bit begins, and it is the 11th wrap after the write.
- R6: `done` stays 1 until a cycle with `done_clr` = 1 clears it. If the frame end and `done_clr` fall in the same cycle, `done` is set.
- R7: `wr_valid` while `wr_ready` is 0 has no effect. The frame in flight continues unchanged and no second frame follows.
- R8: `rate_sel` selects the sample tick. 0 gives one tick every FAST_DIV clocks, which is 32 clocks per bit by default. 1 gives one tick every SLOW_DIV clocks, which is 64 clocks per bit by default. 2 or 3 takes each clock with `ext_tick` = 1 as one tick.
- R9: Frames end correctly for any payload. This includes payloads whose loaded bits already look like the end pattern, such as 0x02 with ninth bit 0, as well as all zeros and all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Sample tick source: 0 fast divide, 1 slow divide, 2 or 3 external |
| ext_tick | input | 1 | External timer overflow pulse, one clock wide per tick |
| wr_valid | input | 1 | Host offers a frame |
| wr_ready | output | 1 | Block is idle and will take a frame |
| wr_data | input | 8 | Payload byte |
| wr_bit9 | input | 1 | Programmable ninth bit |
| done_clr | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial line, high when idle |
| done | output | 1 | Sticky frame-complete flag |

## Verification
Two pairs of events can land in the same cycle. The first is the end of a frame setting `done` while the host is asserting `done_clr`. The second is a write being taken on the very edge where the oversampling counter wraps. For the first, the bench holds `done_clr` high across an entire frame and expects `done` high in the end cycle and low one cycle later. For the second, it times the write against its own count of the external ticks it has driven and expects the start bit a full bit time later rather than at once. A behavioural model tracks the pending frame, the wrap count and the flag, and it is compared with `txd`, `done` and `wr_ready` on every clock.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  typedef enum logic [1:0] {
    RATE_DIV_FAST = 2'd0,
    RATE_DIV_SLOW = 2'd1,
    RATE_EXT      = 2'd2,
    RATE_EXT_ALT  = 2'd3
  } rate_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_START = 2'd2,
    PH_DATA  = 2'd3
  } tx_phase_e;
endpackage

// File: rtl/uart9_rate_gen.sv
module uart9_rate_gen #(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       ext_tick,
  output logic       sample_tick
);
  import uart9_pkg::*;
  localparam int CW = $clog2(SLOW_DIV + 1);

  rate_sel_e      mode;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  lim;
  logic           int_tick;

  assign mode = rate_sel_e'(rate_sel);

  always_comb begin
    case (mode)
      RATE_DIV_FAST: lim = CW'(FAST_DIV - 1);
      default:       lim = CW'(SLOW_DIV - 1);
    endcase
  end

  // >= also recovers cleanly when the ratio is switched down mid-count
  assign int_tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (int_tick) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign sample_tick = (mode == RATE_EXT || mode == RATE_EXT_ALT) ? ext_tick : int_tick;
endmodule

// File: rtl/uart9_ovs_div.sv
module uart9_ovs_div #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic roll
);
  localparam int W = $clog2(OVS);
  logic [W-1:0] cnt;

  assign roll = tick && (cnt == W'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (roll) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart9_shreg.sv
module uart9_shreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          load_top,
  input  logic          shift,
  output logic          tx_bit,
  output logic          last_bit
);
  localparam int SW = DW + 1;
  logic [SW-1:0] sh;
  logic          marked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      marked <= 1'b0;
    end else if (load) begin
      sh     <= {load_top, load_data};
      marked <= 1'b0;
    end else if (shift) begin
      sh     <= {~marked, sh[SW-1:1]};
      marked <= 1'b1;
    end
  end

  assign tx_bit   = sh[0];
  assign last_bit = marked && sh[1] && (sh[SW-1:2] == '0);

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && marked && !load) |=> (sh[SW-1] == 1'b0)); // R9
endmodule

// File: rtl/uart9_tx_ctrl.sv
module uart9_tx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic roll,
  input  logic last_bit,
  input  logic done_clr,
  output logic wr_ready,
  output logic load,
  output logic shift,
  output logic send,
  output logic data_on,
  output logic done
);
  import uart9_pkg::*;
  tx_phase_e phase;
  logic      finish;

  assign wr_ready = (phase == PH_IDLE);
  assign load     = wr_valid && wr_ready;
  assign shift    = roll && (phase == PH_DATA);
  assign finish   = shift && last_bit;
  assign send     = (phase == PH_START) || (phase == PH_DATA);
  assign data_on  = (phase == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else begin
      case (phase)
        PH_IDLE:  if (load)   phase <= PH_WAIT;
        PH_WAIT:  if (roll)   phase <= PH_START;
        PH_START: if (roll)   phase <= PH_DATA;
        PH_DATA:  if (finish) phase <= PH_IDLE;
        default:              phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done <= 1'b0;
    else if (finish)   done <= 1'b1;
    else if (done_clr) done <= 1'b0;
  end

  AST_START_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send) |-> $past(roll)); // R3
  AST_DONE_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(roll)); // R5
  AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(send) |-> done); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done); // R6
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel,
  input  logic              ext_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              done_clr,
  output logic              txd,
  output logic              done
);
  logic sample_tick, roll, load, shift, send, data_on, tx_bit, last_bit;

  uart9_rate_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_rate (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .ext_tick(ext_tick),
    .sample_tick(sample_tick));

  uart9_ovs_div #(.OVS(OVS)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .roll(roll));

  uart9_tx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .roll(roll),
    .last_bit(last_bit), .done_clr(done_clr), .wr_ready(wr_ready),
    .load(load), .shift(shift), .send(send), .data_on(data_on), .done(done));

  uart9_shreg #(.DW(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(wr_data),
    .load_top(wr_bit9), .shift(shift), .tx_bit(tx_bit), .last_bit(last_bit));

  assign txd = !send ? 1'b1 : (data_on ? tx_bit : 1'b0);

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !roll) |=> ($stable(txd) && !wr_ready)); // R7
endmodule

// File: tb/sim_uart9_tx.sv
module sim_uart9_tx;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'd2;
  logic       ext_tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = 8'h00;
  logic       wr_bit9 = 1'b0;
  logic       done_clr = 1'b0;
  logic       txd, done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tick_gap = 1;
  bit tick_on  = 1'b1;
  bit model_on = 1'b0;

  // behavioural model state
  int       m_ticks = 0;
  bit       m_pend = 0, m_act = 0, m_done = 0;
  int       m_s = 0;
  bit [8:0] m_frame = '0;

  uart9_tx u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .ext_tick(ext_tick),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_bit9(wr_bit9), .done_clr(done_clr), .txd(txd), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) ext_tick = tick_on && (cyc % tick_gap == 0);

  task automatic chk(input bit ok, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  // model update on every edge
  always @(posedge clk) begin
    bit roll_m, rdy, set;
    if (!rst_n) begin
      m_ticks = 0; m_pend = 0; m_act = 0; m_done = 0; m_s = 0;
    end else begin
      roll_m = (rate_sel >= 2) && ext_tick && (m_ticks % 16 == 15);
      if ((rate_sel >= 2) && ext_tick) m_ticks++;
      rdy = !m_pend && !m_act;
      set = 0;
      if (roll_m) begin
        if (m_act) begin
          m_s++;
          if (m_s == 10) begin m_act = 0; set = 1; end
        end else if (m_pend) begin
          m_act = 1; m_s = 0; m_pend = 0;
        end
      end
      if (set) m_done = 1;
      else if (done_clr) m_done = 0;
      if (wr_valid && rdy) begin
        m_pend = 1;
        m_frame = {wr_bit9, wr_data};
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    bit exp_txd;
    if (model_on && rst_n) begin
      if (!m_act)        exp_txd = 1'b1;
      else if (m_s == 0) exp_txd = 1'b0;
      else               exp_txd = m_frame[m_s-1];
      chk(txd == exp_txd, "R4 txd", txd, exp_txd);
      chk(done == m_done, "R6 done", done, m_done);
      chk(wr_ready == (!m_pend && !m_act), "R2 wr_ready", wr_ready, !m_pend && !m_act);
    end
  end

  task automatic put(input logic [7:0] d, input logic b9);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_bit9 = b9;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(wr_ready == 1'b0, "R2 ready low after accept", wr_ready, 0);
  endtask

  task automatic finish_and_clear();
    while (!done) @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
  endtask

  task automatic frame(input logic [7:0] d, input logic b9);
    put(d, b9);
    finish_and_clear();
  endtask

  task automatic span_check(input int expect_clks, input string tag);
    int k = 0;
    while (txd) @(negedge clk);
    while (!done) begin @(negedge clk); k++; end
    chk(k == expect_clks, tag, k, expect_clks);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got %0d expected %0d", WATCHDOG, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(done == 1'b0, "R1 done low", done, 0);
    chk(wr_ready == 1'b1, "R1 ready high", wr_ready, 1);
    model_on = 1'b1;

    // R3: write on the wrap edge -> start one full bit later
    while (m_ticks % 16 != 15) @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'h5A; wr_bit9 = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    begin
      int k = 0;
      while (txd) begin @(negedge clk); k++; end
      chk(k == 16, "R3 start delay", k, 16);
    end
    // R5: start to done = 10 bit times of 16 ticks
    begin
      int k = 0;
      while (!done) begin @(negedge clk); k++; end
      chk(k == 160, "R5 frame span", k, 160);
      chk(txd == 1'b1 && wr_ready == 1'b1, "R5 line and ready at end", {txd, wr_ready}, 3);
    end
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;

    // R9 payload patterns, some mimicking the end pattern
    frame(8'h02, 1'b0);
    frame(8'h00, 1'b1);
    frame(8'hFF, 1'b1);
    tick_gap = 3;
    frame(8'hA5, 1'b0);
    frame(8'h01, 1'b0);
    chk(fails == 0, "R9 patterns clean", fails, 0);

    // R7: writes while busy are ignored
    put(8'h3C, 1'b1);
    repeat (20) @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'hC3; wr_bit9 = 1'b0;
    chk(wr_ready == 1'b0, "R7 busy", wr_ready, 0);
    repeat (40) @(negedge clk);
    wr_valid = 1'b0;
    finish_and_clear();
    repeat (60) @(negedge clk);
    chk(txd == 1'b1 && done == 1'b0, "R7 no extra frame", {txd, done}, 2);

    // R6: clear held across the end -> set wins, then clears
    tick_gap = 1;
    put(8'h81, 1'b1);
    done_clr = 1'b1;
    while (!wr_ready) @(negedge clk);
    chk(done == 1'b1, "R6 set wins over clear", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R6 cleared next cycle", done, 0);
    done_clr = 1'b0;
    repeat (5) @(negedge clk);
    chk(done == 1'b0, "R6 stays clear", done, 0);

    // R8: internal dividers
    model_on = 1'b0;
    tick_on = 1'b0;
    rate_sel = 2'd0;
    put(8'h96, 1'b0);
    span_check(320, "R8 fast divide span");
    finish_and_clear();
    rate_sel = 2'd1;
    put(8'h69, 1'b1);
    span_check(640, "R8 slow divide span");
    finish_and_clear();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule